// File: doc/BRIEF.md
# Synchronous Card Header Reader

This block reads the fixed header that a synchronous-protocol card sends once its reset line has been released. When `start` is raised after the reset line falls, the block waits a programmed lead time. It then toggles a slow card clock with programmed high and low phases. On each rising card-clock edge it samples the card's I/O line.

After 32 pulses the block holds the assembled header on a valid/ready output, together with two 8-bit fields:
- a protocol code, made of the first eight bits received;
- a protocol-parameter code, made of the next eight bits.

A flag marks protocol codes that are not allowed, so that a higher layer can deactivate the contacts.

The card changes its data after each falling card-clock edge, so every bit is taken on the following rising edge. All durations are whole microseconds, converted to system-clock cycles through `CLK_PER_US`. The block refuses to elaborate if any duration lies outside these windows:

| Duration | Allowed window |
|---|---|
| Lead time before the first pulse | 10 to 100 us |
| High phase | 10 to 50 us |
| Low phase | 10 to 100 us |
| High plus low (one bit period) | 20 to 142 us, about 7 to 50 kbit/s |

Back-pressure: `hdr_valid` stays high, and `header`, `proto_code`, `proto_param` and `proto_bad` stay frozen, until a cycle with `hdr_ready` high. A transfer completes on a clock edge where both are high, and `hdr_valid` is low from the next cycle on. No new capture can start while a header is waiting.

Top module: `sync_header_reader`

## Requirements
- R1: After reset, `card_clk`, `busy`, `hdr_valid` and `proto_bad` are 0. `card_clk` is never high while `busy` is low.
- R2: The first rising edge of `card_clk` comes LEAD_US*CLK_PER_US cycles after the clock edge that accepts `start`. During those cycles `card_clk` is low and `busy` is high.
- R3: Every high phase of `card_clk` lasts HIGH_US*CLK_PER_US cycles. Every low phase between two pulses of one capture lasts LOW_US*CLK_PER_US cycles.
- R4: A capture produces exactly 32 rising edges of `card_clk`. After the 32nd pulse falls, `card_clk` stays low and `busy` drops as `hdr_valid` rises.
- R5: The I/O level sampled at the k-th rising edge (k = 1..32) lands in `header[k-1]`, so the first bit received is the least significant. A high level gives 1 and a low level gives 0.
- R6: `proto_code` equals `header[7:0]` and `proto_param` equals `header[15:8]`.
- R7: `proto_bad` is 1 exactly when `hdr_valid` is 1 and `proto_code` is 8'h00 or 8'hFF.
- R8: While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid` stays high and `header` does not change. After a cycle with both high, `hdr_valid` is 0.
- R9: `start` is ignored while `busy` or `hdr_valid` is high. The ongoing capture keeps its timing and result, and no new capture begins after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a capture; the card's reset line has just fallen |
| io_in | input | 1 | Card I/O line, synchronised to `clk` |
| card_clk | output | 1 | Clock driven to the card |
| busy | output | 1 | Capture in progress |
| hdr_valid | output | 1 | Header available |
| hdr_ready | input | 1 | Consumer accepts the header |
| header | output | 32 | Assembled header, first bit received in bit 0 |
| proto_code | output | 8 | Protocol code (`header[7:0]`) |
| proto_param | output | 8 | Protocol-parameter code (`header[15:8]`) |
| proto_bad | output | 1 | Protocol code 8'h00 or 8'hFF while the header is valid |

## Verification
The checker assumes that `io_in` has already been synchronised to `clk`. It also assumes that `rst_n` is not pulsed in the middle of a capture, because its phase-length counters are not realigned to a partial pulse. The stimulus applies reset only once, at time zero. It drives `start` and `hdr_ready` only on falling system-clock edges. It models the card by stepping its bit index on each falling card-clock edge, so `io_in` never changes near a sampling edge. Extra `start` pulses, both in mid-capture and during a held header, exercise the ignore rule without ever breaking these assumptions.

// File: rtl/sh_pkg.sv
package sh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } sh_state_e;
endpackage

// File: rtl/sh_phase_timer.sv
module sh_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sh_bit_assembler.sv
module sh_bit_assembler #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [NBITS-1:0] word,
  output logic             full
);
  localparam int CW = $clog2(NBITS + 1);
  logic [CW-1:0] count;

  // Right shift: the earliest bit ends up in bit 0 once NBITS bits are in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else if (clear) begin
      word  <= '0;
      count <= '0;
    end else if (shift_en && !full) begin
      word  <= {bit_in, word[NBITS-1:1]};
      count <= count + 1'b1;
    end
  end

  assign full = (count == CW'(NBITS));
endmodule

// File: rtl/sync_header_reader.sv
module sync_header_reader
  import sh_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int LEAD_US    = 20,
  parameter int HIGH_US    = 20,
  parameter int LOW_US     = 20,
  parameter int HDR_BITS   = 32,
  parameter int FIELD_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  io_in,
  output logic                  card_clk,
  output logic                  busy,
  output logic                  hdr_valid,
  input  logic                  hdr_ready,
  output logic [HDR_BITS-1:0]   header,
  output logic [FIELD_BITS-1:0] proto_code,
  output logic [FIELD_BITS-1:0] proto_param,
  output logic                  proto_bad
);
  localparam int LEAD_CYC = LEAD_US * CLK_PER_US;
  localparam int HIGH_CYC = HIGH_US * CLK_PER_US;
  localparam int LOW_CYC  = LOW_US * CLK_PER_US;
  localparam int MAX_A    = (LEAD_CYC > HIGH_CYC) ? LEAD_CYC : HIGH_CYC;
  localparam int MAX_CYC  = (MAX_A > LOW_CYC) ? MAX_A : LOW_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  // Elaboration-time window checks
  if (LEAD_US < 10 || LEAD_US > 100) begin : g_bad_lead
    $error("lead time must be 10..100 us");
  end
  if (HIGH_US < 10 || HIGH_US > 50) begin : g_bad_high
    $error("high phase must be 10..50 us");
  end
  if (LOW_US < 10 || LOW_US > 100) begin : g_bad_low
    $error("low phase must be 10..100 us");
  end
  if (HIGH_US + LOW_US < 20 || HIGH_US + LOW_US > 142) begin : g_bad_rate
    $error("bit period must give 7..50 kbit/s");
  end
  if (HDR_BITS < 2 * FIELD_BITS || CLK_PER_US < 1) begin : g_bad_shape
    $error("header too short for two fields or zero clock rate");
  end

  sh_state_e     state, state_nx;
  logic          tmr_load, tmr_expired, sh_clear, sh_shift, sh_full;
  logic [TW-1:0] tmr_val;

  sh_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sh_bit_assembler #(.NBITS(HDR_BITS)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sh_clear),
    .shift_en (sh_shift),
    .bit_in   (io_in),
    .word     (header),
    .full     (sh_full)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_clear = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_nx = ST_LEAD;
        tmr_load = 1'b1;
        tmr_val  = TW'(LEAD_CYC - 1);
        sh_clear = 1'b1;
      end
      ST_LEAD, ST_LOW: if (tmr_expired) begin
        // rising card clock: take the bit the card set up on the last fall
        state_nx = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TW'(HIGH_CYC - 1);
        sh_shift = 1'b1;
      end
      ST_HIGH: if (tmr_expired) begin
        if (sh_full) begin
          state_nx = ST_DONE;
        end else begin
          state_nx = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = TW'(LOW_CYC - 1);
        end
      end
      ST_DONE: if (hdr_ready) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      card_clk <= 1'b0;
    end else begin
      state    <= state_nx;
      card_clk <= (state_nx == ST_HIGH);
    end
  end

  assign busy        = (state == ST_LEAD) || (state == ST_HIGH) || (state == ST_LOW);
  assign hdr_valid   = (state == ST_DONE);
  assign proto_code  = header[FIELD_BITS-1:0];
  assign proto_param = header[2*FIELD_BITS-1:FIELD_BITS];
  assign proto_bad   = hdr_valid && ((proto_code == '0) || (&proto_code));
endmodule

// File: rtl/sh_reader_chk.sv
module sh_reader_chk #(
  parameter int LEAD_CYC = 40,
  parameter int HIGH_CYC = 30,
  parameter int LOW_CYC  = 50,
  parameter int HDR_BITS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                card_clk,
  input logic                busy,
  input logic                hdr_valid,
  input logic                hdr_ready,
  input logic [HDR_BITS-1:0] header,
  input logic                proto_bad
);
  int   hi_cnt, lo_cnt, rise_cnt;
  logic clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= 0;
      lo_cnt   <= 0;
      rise_cnt <= 0;
      clk_d    <= 1'b0;
    end else begin
      clk_d  <= card_clk;
      hi_cnt <= card_clk ? hi_cnt + 1 : 0;
      lo_cnt <= (card_clk || !busy) ? 0 : lo_cnt + 1;
      if (!busy && !card_clk)       rise_cnt <= 0;
      else if (card_clk && !clk_d)  rise_cnt <= rise_cnt + 1;
    end
  end

  assert_idle_clk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !card_clk);
  assert_lead_and_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> lo_cnt == ((rise_cnt == 0) ? LEAD_CYC : LOW_CYC));
  assert_high_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> hi_cnt == HIGH_CYC);
  assert_rise_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= HDR_BITS);
  assert_bad_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_bad |-> hdr_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(header));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_valid);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || hdr_valid);
  assert_valid_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !busy);
endmodule

bind sync_header_reader sh_reader_chk #(
  .LEAD_CYC (LEAD_CYC),
  .HIGH_CYC (HIGH_CYC),
  .LOW_CYC  (LOW_CYC),
  .HDR_BITS (HDR_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_clk  (card_clk),
  .busy      (busy),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .header    (header),
  .proto_bad (proto_bad)
);

// File: tb/sync_header_reader_tb.sv
`timescale 1ns/1ps
module sync_header_reader_tb;
  localparam int CPU  = 2;
  localparam int LEAD = 20 * CPU;
  localparam int HIGH = 15 * CPU;
  localparam int LOW  = 25 * CPU;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, hdr_ready = 1'b0;
  logic        io_in, card_clk, busy, hdr_valid, proto_bad;
  logic [31:0] header, model = '0;
  logic [7:0]  proto_code, proto_param;

  int checks = 0, failures = 0, cyc = 0;
  int rises = 0, cap_rises = 0, hi_len = 0, lo_len = 0, bidx = 0;
  int hi_err = 0, lead_err = 0, low_err = 0;
  logic prev_clk = 1'b0;

  always #4 clk = ~clk;

  sync_header_reader #(.CLK_PER_US(CPU), .LEAD_US(20), .HIGH_US(15), .LOW_US(25)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .io_in(io_in), .card_clk(card_clk),
    .busy(busy), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .header(header),
    .proto_code(proto_code), .proto_param(proto_param), .proto_bad(proto_bad)
  );

  // card model: bit index steps on each falling card clock
  assign io_in = (bidx < 32) ? model[bidx] : 1'b0;

  always @(negedge clk) begin
    if (card_clk) begin
      if (!prev_clk) begin
        if (lo_len != ((cap_rises == 0) ? LEAD : LOW)) begin
          if (cap_rises == 0) lead_err++; else low_err++;
        end
        rises++;
        cap_rises++;
      end
      hi_len++;
      lo_len = 0;
    end else begin
      if (prev_clk) begin
        if (hi_len != HIGH) hi_err++;
        bidx++;
      end
      hi_len = 0;
      if (busy) lo_len++;
      else begin lo_len = 0; cap_rises = 0; bidx = 0; end
    end
    prev_clk = card_clk;
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bad(input logic [31:0] h);
    return (h[7:0] == 8'h00) || (h[7:0] == 8'hFF);
  endfunction

  task automatic capture(input logic [31:0] h, input int hold, input bit poke_busy, input bit poke_hold);
    int rb, lb, lw, hb, n;
    logic stable;
    rb = rises; lb = lead_err; lw = low_err; hb = hi_err;
    model = h;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!hdr_valid && n < 6000) begin
      @(negedge clk);
      n++;
      start = (poke_busy && n == 300);
    end
    start = 1'b0;
    chk("R4 rise count", (rises - rb) == 32, rises - rb, 32);
    chk("R4 clk low at done", hdr_valid && !card_clk && !busy, {card_clk, busy}, 0);
    chk("R2 lead errors", lead_err == lb, lead_err - lb, 0);
    chk("R3 phase errors", hi_err == hb && low_err == lw, (hi_err - hb) + (low_err - lw), 0);
    chk("R5 header", header == h, header, h);
    chk("R6 fields", proto_code == h[7:0] && proto_param == h[15:8], {proto_param, proto_code}, h[15:0]);
    chk("R7 bad flag", proto_bad == exp_bad(h), proto_bad, exp_bad(h));
    stable = 1'b1;
    for (int i = 0; i < hold; i++) begin
      start = poke_hold;
      @(negedge clk);
      if (!hdr_valid || header != h) stable = 1'b0;
    end
    start = 1'b0;
    chk("R8 hold stable", stable, header, h);
    hdr_ready = 1'b1;
    @(negedge clk) hdr_ready = 1'b0;
    chk("R8 release", !hdr_valid && !proto_bad, {hdr_valid, proto_bad}, 0);
    rb = rises;
    repeat (60) @(negedge clk);
    chk("R9 no restart", !busy && rises == rb, busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset state", !card_clk && !busy && !hdr_valid && !proto_bad,
        {card_clk, busy, hdr_valid, proto_bad}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle clock", !card_clk && !busy, {card_clk, busy}, 0);
    capture(32'hA5C3_7E01, 0, 1'b0, 1'b0);
    capture(32'h1234_56FF, 3, 1'b1, 1'b0);   // R7 code FF, R9 start mid-capture
    capture(32'h8001_BE00, 7, 1'b0, 1'b1);   // R7 code 00, R9 start during hold
    capture(32'hFFFF_FFFE, 1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      capture($urandom, int'($urandom_range(0, 9)), k[0], k[1]);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule